// File: doc/BRIEF.md
# Dual FIFO with Coded Fill-Level Interrupts

This block holds two independent synchronous FIFOs of the same power-of-two depth. One serves the receive direction and one serves the transmit direction. Each side has a push/pop handshake. Each side reports full and empty flags and an occupancy count. The read side is show-ahead: the oldest entry is on the read data port whenever the FIFO is not empty.

Each direction has a 3-bit level code. The code selects a fraction of the depth, and the block compares that fraction against the fill level. The receive side measures stored entries. The transmit side measures free entries. When the selected point is reached and that direction's enable is set, a level interrupt is raised. A combined interrupt output is the OR of the two directions. A serial engine and a bus interface sit around the block but are not part of it.

Top module: `dual_fifo_lvl_irq`

## Requirements
- R1: After reset both FIFOs are empty, both counts are 0, neither is full, and with both enables clear all three interrupt outputs are 0.
- R2: Each FIFO returns its entries in push order. The read data port shows the oldest stored entry whenever the FIFO is not empty.
- R3: A push to a full FIFO is ignored. The count stays at DEPTH and the stored data is unchanged.
- R4: A pop from an empty FIFO is ignored. The count stays 0.
- R5: A push and a pop in the same cycle on a FIFO that is neither full nor empty leave its count unchanged.
- R6: With receive code 0, 1, 2, 3 or 4, the receive condition holds when the count is at least DEPTH×1/8, ×2/8, ×4/8, ×6/8 or ×7/8 respectively.
- R7: With receive code 5, the receive condition holds exactly when the receive FIFO is full.
- R8: With transmit code 0 to 4, the transmit condition holds when the number of free entries (DEPTH minus count) is at least the same fraction of DEPTH as in R6.
- R9: With transmit code 5, the transmit condition holds exactly when the transmit FIFO is empty.
- R10: Codes 6 and 7 never raise the interrupt of their direction.
- R11: A direction's interrupt is a level signal. It equals its condition ANDed with its enable, follows the count in the same cycle, and drops as soon as the condition stops holding.
- R12: The combined interrupt is high exactly when at least one direction's interrupt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_push | input | 1 | Write request, receive FIFO |
| rx_wdata | input | WIDTH | Write data, receive FIFO |
| rx_pop | input | 1 | Read request, receive FIFO |
| rx_rdata | output | WIDTH | Oldest entry, receive FIFO |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_count | output | CNT_W | Receive occupancy |
| tx_push | input | 1 | Write request, transmit FIFO |
| tx_wdata | input | WIDTH | Write data, transmit FIFO |
| tx_pop | input | 1 | Read request, transmit FIFO |
| tx_rdata | output | WIDTH | Oldest entry, transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_count | output | CNT_W | Transmit occupancy |
| rx_lvl_code | input | 3 | Receive level code |
| tx_lvl_code | input | 3 | Transmit level code |
| rx_lvl_ie | input | 1 | Receive level interrupt enable |
| tx_lvl_ie | input | 1 | Transmit level interrupt enable |
| rx_lvl_irq | output | 1 | Receive level interrupt |
| tx_lvl_irq | output | 1 | Transmit level interrupt |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situations to reach are the exact edges of each coded threshold. Each needs a specific count, and the ones near the top fraction and the full and empty codes lie at the ends of the range. Overflow and underflow pushes at those same edges are also hard to reach. For each of the eight codes, the stimulus steps both FIFOs one entry at a time from empty to beyond full and back to beyond empty. Every intermediate count, and each ignored push and pop, is therefore visited under that code. Random push, pop and enable traffic then follows, including same-cycle push and pop at mid fill.

// File: rtl/dual_fifo_lvl_pkg.sv
package dual_fifo_lvl_pkg;

   // Fill point in entries for a level code; -1 means the code never triggers.
   function automatic int lvl_target(input logic [2:0] code, input int depth);
      case (code)
         3'd0:    return depth / 8;
         3'd1:    return depth / 4;
         3'd2:    return depth / 2;
         3'd3:    return (depth * 3) / 4;
         3'd4:    return (depth * 7) / 8;
         3'd5:    return depth;
         default: return -1;
      endcase
   endfunction

endpackage

// File: rtl/lvl_sync_fifo.sv
module lvl_sync_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty,
   output logic [CNT_W-1:0] count
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/lvl_thresh.sv
module lvl_thresh
   import dual_fifo_lvl_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter bit MEASURE_FREE = 1'b0,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic [CNT_W-1:0] count,
   input  logic [2:0]       code,
   input  logic             ie,
   output logic             irq
);

   logic [CNT_W-1:0] level;
   logic             hit;
   int               target;

   generate
      if (MEASURE_FREE) begin : g_free
         assign level = CNT_W'(DEPTH) - count;
      end else begin : g_used
         assign level = count;
      end
   endgenerate

   always_comb begin
      target = lvl_target(code, DEPTH);
      hit    = (target >= 0) && (int'(level) >= target);
   end

   assign irq = ie && hit;

endmodule

// File: rtl/dual_fifo_lvl_irq.sv
module dual_fifo_lvl_irq #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_push,
   input  logic [WIDTH-1:0] rx_wdata,
   input  logic             rx_pop,
   output logic [WIDTH-1:0] rx_rdata,
   output logic             rx_full,
   output logic             rx_empty,
   output logic [CNT_W-1:0] rx_count,
   input  logic             tx_push,
   input  logic [WIDTH-1:0] tx_wdata,
   input  logic             tx_pop,
   output logic [WIDTH-1:0] tx_rdata,
   output logic             tx_full,
   output logic             tx_empty,
   output logic [CNT_W-1:0] tx_count,
   input  logic [2:0]       rx_lvl_code,
   input  logic [2:0]       tx_lvl_code,
   input  logic             rx_lvl_ie,
   input  logic             tx_lvl_ie,
   output logic             rx_lvl_irq,
   output logic             tx_lvl_irq,
   output logic             irq
);

   generate
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 8");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("WIDTH must be at least 1");
      end
   endgenerate

   lvl_sync_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
      .rdata(rx_rdata), .full(rx_full), .empty(rx_empty), .count(rx_count)
   );

   lvl_sync_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
      .rdata(tx_rdata), .full(tx_full), .empty(tx_empty), .count(tx_count)
   );

   lvl_thresh #(.DEPTH(DEPTH), .MEASURE_FREE(1'b0)) u_rx_lvl (
      .count(rx_count), .code(rx_lvl_code), .ie(rx_lvl_ie), .irq(rx_lvl_irq)
   );

   lvl_thresh #(.DEPTH(DEPTH), .MEASURE_FREE(1'b1)) u_tx_lvl (
      .count(tx_count), .code(tx_lvl_code), .ie(tx_lvl_ie), .irq(tx_lvl_irq)
   );

   assign irq = rx_lvl_irq | tx_lvl_irq;

endmodule

// File: rtl/dual_fifo_lvl_irq_chk.sv
module dual_fifo_lvl_irq_chk #(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_push,
   input logic             rx_pop,
   input logic             rx_full,
   input logic             rx_empty,
   input logic [CNT_W-1:0] rx_count,
   input logic             tx_push,
   input logic             tx_pop,
   input logic             tx_empty,
   input logic [2:0]       rx_lvl_code,
   input logic [2:0]       tx_lvl_code,
   input logic             rx_lvl_ie,
   input logic             tx_lvl_ie,
   input logic             rx_lvl_irq,
   input logic             tx_lvl_irq,
   input logic             irq
);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full && rx_push && !rx_pop |=> rx_count == CNT_W'(DEPTH));

   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty && tx_pop && !tx_push |=> tx_empty);

   assert_pushpop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_full && !rx_empty && rx_push && rx_pop |=> $stable(rx_count));

   assert_rx_full_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_lvl_code == 3'd5 |-> rx_lvl_irq == (rx_lvl_ie && rx_full));

   assert_tx_empty_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_lvl_code == 3'd5 |-> tx_lvl_irq == (tx_lvl_ie && tx_empty));

   assert_dead_codes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_lvl_code[2:1] == 2'b11 |-> !rx_lvl_irq) and (tx_lvl_code[2:1] == 2'b11 |-> !tx_lvl_irq));

   assert_enable_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_lvl_ie |-> !rx_lvl_irq) and (!tx_lvl_ie |-> !tx_lvl_irq));

   assert_combined_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> !rx_lvl_irq && !tx_lvl_irq);

endmodule

bind dual_fifo_lvl_irq dual_fifo_lvl_irq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full),
   .rx_empty(rx_empty), .rx_count(rx_count), .tx_push(tx_push), .tx_pop(tx_pop),
   .tx_empty(tx_empty), .rx_lvl_code(rx_lvl_code), .tx_lvl_code(tx_lvl_code),
   .rx_lvl_ie(rx_lvl_ie), .tx_lvl_ie(tx_lvl_ie), .rx_lvl_irq(rx_lvl_irq),
   .tx_lvl_irq(tx_lvl_irq), .irq(irq)
);

// File: tb/dual_fifo_lvl_irq_bench.sv
module dual_fifo_lvl_irq_bench;
   localparam int WIDTH = 8;
   localparam int DEPTH = 16;
   localparam int CNT_W = $clog2(DEPTH) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
   logic [WIDTH-1:0] rx_wdata = '0, tx_wdata = '0;
   logic [WIDTH-1:0] rx_rdata, tx_rdata;
   logic rx_full, rx_empty, tx_full, tx_empty;
   logic [CNT_W-1:0] rx_count, tx_count;
   logic [2:0] rx_lvl_code = 3'd0, tx_lvl_code = 3'd0;
   logic rx_lvl_ie = 0, tx_lvl_ie = 0;
   logic rx_lvl_irq, tx_lvl_irq, irq;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   int rxq[$];
   int txq[$];

   always #2 clk = ~clk;

   dual_fifo_lvl_irq #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dual_fifo_lvl_irq (.*);

   function automatic int frac_pt(input int code);
      int num[5] = '{1, 2, 4, 6, 7};
      if (code < 5) return (DEPTH * num[code]) / 8;
      if (code == 5) return DEPTH;
      return -1;
   endfunction

   function automatic string code_tag(input int code, input bit is_tx);
      if (code >= 6) return "R10";
      if (code == 5) return is_tx ? "R9" : "R7";
      return is_tx ? "R8" : "R6";
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      int rt, tt;
      bit rh, th;
      chk("R5 rx count", int'(rx_count), rxq.size());
      chk("R5 tx count", int'(tx_count), txq.size());
      chk("R3 rx full", int'(rx_full), int'(rxq.size() == DEPTH));
      chk("R3 tx full", int'(tx_full), int'(txq.size() == DEPTH));
      chk("R4 rx empty", int'(rx_empty), int'(rxq.size() == 0));
      chk("R4 tx empty", int'(tx_empty), int'(txq.size() == 0));
      if (rxq.size() > 0) chk("R2 rx data", int'(rx_rdata), rxq[0]);
      if (txq.size() > 0) chk("R2 tx data", int'(tx_rdata), txq[0]);
      rt = frac_pt(int'(rx_lvl_code));
      tt = frac_pt(int'(tx_lvl_code));
      rh = rx_lvl_ie && rt >= 0 && rxq.size() >= rt;
      th = tx_lvl_ie && tt >= 0 && (DEPTH - txq.size()) >= tt;
      chk(rx_lvl_ie ? code_tag(int'(rx_lvl_code), 0) : "R11 rx gate", int'(rx_lvl_irq), int'(rh));
      chk(tx_lvl_ie ? code_tag(int'(tx_lvl_code), 1) : "R11 tx gate", int'(tx_lvl_irq), int'(th));
      chk("R12 combined", int'(irq), int'(rh || th));
   endtask

   task automatic step(input bit rpu, input bit rpo, input bit tpu, input bit tpo);
      bit rdo_pu, rdo_po, tdo_pu, tdo_po;
      rx_push = rpu; rx_pop = rpo; tx_push = tpu; tx_pop = tpo;
      rx_wdata = WIDTH'($urandom); tx_wdata = WIDTH'($urandom);
      @(posedge clk);
      rdo_pu = rpu && rxq.size() < DEPTH; rdo_po = rpo && rxq.size() > 0;
      tdo_pu = tpu && txq.size() < DEPTH; tdo_po = tpo && txq.size() > 0;
      if (rdo_po) void'(rxq.pop_front());
      if (rdo_pu) rxq.push_back(int'(rx_wdata));
      if (tdo_po) void'(txq.pop_front());
      if (tdo_pu) txq.push_back(int'(tx_wdata));
      @(negedge clk);
      compare();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset rx count", int'(rx_count), 0);
      chk("R1 reset tx count", int'(tx_count), 0);
      chk("R1 reset rx empty", int'(rx_empty), 1);
      chk("R1 reset tx empty", int'(tx_empty), 1);
      chk("R1 reset irq", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare();
      for (int c = 0; c < 8; c++) begin
         rx_lvl_code = 3'(c); tx_lvl_code = 3'(c);
         rx_lvl_ie = 1'b1; tx_lvl_ie = 1'b1;
         repeat (DEPTH + 3) step(1, 0, 1, 0);
         step(1, 1, 1, 1);
         repeat (DEPTH + 3) step(0, 1, 0, 1);
         repeat (DEPTH / 2) step(1, 0, 1, 0);
         repeat (4) step(1, 1, 1, 1);
         for (int i = 0; i < 60; i++)
            step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
         repeat (DEPTH + 2) step(0, 1, 0, 1);
      end
      for (int i = 0; i < 400; i++) begin
         rx_lvl_code = 3'($urandom); tx_lvl_code = 3'($urandom);
         rx_lvl_ie = 1'($urandom); tx_lvl_ie = 1'($urandom);
         step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule